// File: doc/BRIEF.md
# Configuration Phase Sequencer

This block steps a programmable device through its four bring-up phases: preparation (memory clear and the open-drain ready handshake), configuration load, start-up and normal operation. It drives the open-drain ready line low while the configuration memory is being cleared. It then watches the wired-AND level of that line, so that several devices, or an external agent, can hold everyone in preparation until all of them are ready. After the line has been seen high for long enough, the sequencer latches the mode pins and opens the load phase. Devices that supply the configuration clock wait longer here, so that chained followers are ready before the load starts.

During the load, a length counter starts at zero and counts configuration clock ticks. The load is complete when that count equals the loaded length value and an end-of-load frame strobe has been seen. The block then enters start-up, where it enables the I/Os, releases the internal reset and raises the done flag, and after a fixed number of cycles it settles in operation.

The reset and program pins can abort a load. The program pin can also force a new load from start-up or operation. A retention option lets any pass after the first successful load skip the memory clear. The block has no data stream: every pin is a plain level or a one-cycle strobe that is sampled on the internal clock. The configuration clock is presented as a one-cycle tick enable.

Top module: `cfg_seq_top`

## Requirements
- R1: On power-on reset the phase output reads 0 (preparation). `mem_clear` is high for exactly CLR_CYC cycles and `init_pull_low` is high during those same cycles. `hdc`=1, `ldc`=0 and `done`=0 throughout.
- R2: While the sensed ready line is low, for example because an outside agent holds it, the block stays in phase 0.
- R3: With `master_mode`=0, the block enters phase 1 (load) once the synchronized ready, reset and program levels have all been high, with the clear finished, for SLAVE_SETTLE (2) consecutive cycles. On that edge it latches `mode_pins` onto `mode_latched`.
- R4: With `master_mode`=1, the qualifying run needed is SLAVE_SETTLE+MASTER_EXTRA (2+6=8) consecutive cycles.
- R5: In phase 1, `init_pull_low`=0, `hdc`=1, `ldc`=0 and `dout_en`=1. `dout_en` is 0 in every other phase.
- R6: The length counter is zero on entry to phase 1 and increments on each cycle with `cclk_tick` high. The block moves to phase 2 (start-up) only on a cycle where the count equals `length_count` and `eoc_frame` is high in that cycle or was high earlier in the same load.
- R7: In phase 1, a low synchronized reset or program level returns the block to phase 0. It stays in phase 0 until both levels are high again.
- R8: In phases 2 and 3, `io_active`, `int_rst_rel` and `done` are 1. Phase 2 lasts SU_CYC cycles and is then followed by phase 3 (operation).
- R9: In phases 2 and 3, a low program level returns the block to phase 0. A low reset level has no effect.
- R10: In phases 2 and 3, `hdc`=0 and `ldc`=1. In phases 0 and 1, `hdc`=1 and `ldc`=0.
- R11: A return to phase 0 after at least one completed load skips the memory clear (`mem_clear` stays 0 and the ready line is released at once) when `keep_mem` is 1.
- R12: The reset, program and ready inputs pass through a two-flop synchronizer. The phase reacts on the third rising edge after an input change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| rst_pin_n | input | 1 | Reset pin, active low, asynchronous to clk |
| prog_pin_n | input | 1 | Program pin, active low, asynchronous to clk |
| init_sense | input | 1 | Sensed level of the wired-AND ready line |
| mode_pins | input | MODE_W | Mode select pins |
| master_mode | input | 1 | 1 when this device sources the configuration clock |
| cclk_tick | input | 1 | One-cycle configuration clock tick |
| length_count | input | LEN_W | Loaded length value |
| eoc_frame | input | 1 | End-of-load frame strobe |
| keep_mem | input | 1 | Skip the memory clear on later passes |
| init_pull_low | output | 1 | 1 pulls the ready line low |
| hdc | output | 1 | High while configuring |
| ldc | output | 1 | Low while configuring |
| done | output | 1 | Configuration finished |
| mem_clear | output | 1 | Memory clear request |
| io_active | output | 1 | Enables user I/Os |
| int_rst_rel | output | 1 | Internal reset released |
| dout_en | output | 1 | Serial data-out path enabled |
| mode_latched | output | MODE_W | Mode value captured on load entry |
| phase | output | 2 | 0 prep, 1 load, 2 start-up, 3 operation |

## Verification
The assertions assume that `master_mode`, `keep_mem` and `length_count` hold steady for the length of a pass. They also assume that `eoc_frame` and `cclk_tick` are meaningful only during a load. The stimulus changes these inputs only while the block sits in preparation or operation, and holds each strobe for one cycle. The ready line is modelled as a wired-AND of the block's own pull-down and an outside hold. This keeps the sensed level consistent with what the block drives. It also exercises the release of a hold coming from outside.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;
  typedef enum logic [1:0] {
    PH_PREP  = 2'd0,
    PH_LOAD  = 2'd1,
    PH_START = 2'd2,
    PH_RUN   = 2'd3
  } phase_e;
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         por_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic st1, st2;
    always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
        st1 <= 1'b0;
        st2 <= 1'b0;
      end else begin
        st1 <= din[i];
        st2 <= st1;
      end
    end
    assign dout[i] = st2;
  end
endmodule

// File: rtl/cfg_len_cnt.sv
module cfg_len_cnt #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             in_load,
  input  logic             tick,
  input  logic             eoc,
  input  logic [LEN_W-1:0] load_len,
  output logic             load_done
);
  logic [LEN_W-1:0] cnt;
  logic             eoc_seen;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cnt      <= '0;
      eoc_seen <= 1'b0;
    end else if (!in_load) begin
      cnt      <= '0;
      eoc_seen <= 1'b0;
    end else begin
      if (tick) cnt <= cnt + 1'b1;
      if (eoc)  eoc_seen <= 1'b1;
    end
  end

  assign load_done = in_load && (cnt == load_len) && (eoc_seen || eoc);

  // R6
  cnt_step_chk: assert property (@(posedge clk) disable iff (!por_n)
    (in_load && tick) |=> (!in_load || cnt == $past(cnt) + 1'b1));
  // R6
  cnt_zero_chk: assert property (@(posedge clk) disable iff (!por_n)
    !in_load |=> (cnt == '0));
endmodule

// File: rtl/cfg_phase_fsm.sv
module cfg_phase_fsm
  import cfg_seq_pkg::*;
#(
  parameter int MODE_W       = 4,
  parameter int CLR_CYC      = 8,
  parameter int SU_CYC       = 4,
  parameter int SLAVE_SETTLE = 2,
  parameter int MASTER_EXTRA = 6
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              s_init,
  input  logic              s_rst_n,
  input  logic              s_prog_n,
  input  logic              master_mode,
  input  logic              keep_mem,
  input  logic [MODE_W-1:0] mode_pins,
  input  logic              load_done,
  output phase_e            phase,
  output logic              clr_busy,
  output logic [MODE_W-1:0] mode_q
);
  localparam int NEED_M = SLAVE_SETTLE + MASTER_EXTRA;
  localparam int HW     = $clog2(NEED_M + 1);
  localparam int CW     = $clog2(CLR_CYC + 1);
  localparam int SW     = $clog2(SU_CYC + 1);
  localparam logic [HW-1:0] LAST_S = HW'(SLAVE_SETTLE - 1);
  localparam logic [HW-1:0] LAST_M = HW'(NEED_M - 1);
  localparam logic [CW-1:0] CLR_RL = CW'(CLR_CYC);
  localparam logic [SW-1:0] SU_LST = SW'(SU_CYC - 1);

  logic [HW-1:0] hi_run;
  logic [CW-1:0] clr_left;
  logic [SW-1:0] su_cnt;
  logic          once;
  logic          qual;
  logic [HW-1:0] hi_last;
  logic [CW-1:0] reload;

  assign qual     = (clr_left == '0) && s_init && s_rst_n && s_prog_n;
  assign hi_last  = master_mode ? LAST_M : LAST_S;
  assign reload   = (keep_mem && once) ? '0 : CLR_RL;
  assign clr_busy = (phase == PH_PREP) && (clr_left != '0);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      phase    <= PH_PREP;
      clr_left <= CLR_RL;
      hi_run   <= '0;
      su_cnt   <= '0;
      once     <= 1'b0;
      mode_q   <= '0;
    end else begin
      unique case (phase)
        PH_PREP: begin
          if (clr_left != '0) clr_left <= clr_left - 1'b1;
          if (qual) begin
            if (hi_run == hi_last) begin
              phase  <= PH_LOAD;
              mode_q <= mode_pins;
              hi_run <= '0;
            end else begin
              hi_run <= hi_run + 1'b1;
            end
          end else begin
            hi_run <= '0;
          end
        end
        PH_LOAD: begin
          if (!s_rst_n || !s_prog_n) begin
            phase    <= PH_PREP;
            clr_left <= reload;
          end else if (load_done) begin
            phase  <= PH_START;
            su_cnt <= '0;
            once   <= 1'b1;
          end
        end
        PH_START: begin
          if (!s_prog_n) begin
            phase    <= PH_PREP;
            clr_left <= reload;
          end else if (su_cnt == SU_LST) begin
            phase <= PH_RUN;
          end else begin
            su_cnt <= su_cnt + 1'b1;
          end
        end
        default: begin
          if (!s_prog_n) begin
            phase    <= PH_PREP;
            clr_left <= reload;
          end
        end
      endcase
    end
  end

  // R2
  hold_prep_chk: assert property (@(posedge clk) disable iff (!por_n)
    (phase == PH_PREP && !s_init) |=> (phase == PH_PREP));
  // R7
  abort_load_chk: assert property (@(posedge clk) disable iff (!por_n)
    (phase == PH_LOAD && (!s_rst_n || !s_prog_n)) |=> (phase == PH_PREP));
  // R9
  run_ignores_rst_chk: assert property (@(posedge clk) disable iff (!por_n)
    (phase == PH_RUN && s_prog_n) |=> (phase == PH_RUN));
  // R7
  prep_exit_chk: assert property (@(posedge clk) disable iff (!por_n)
    (phase == PH_PREP && (!s_rst_n || !s_prog_n)) |=> (phase == PH_PREP));
endmodule

// File: rtl/cfg_seq_top.sv
module cfg_seq_top
  import cfg_seq_pkg::*;
#(
  parameter int MODE_W       = 4,
  parameter int LEN_W        = 16,
  parameter int CLR_CYC      = 8,
  parameter int SU_CYC       = 4,
  parameter int SLAVE_SETTLE = 2,
  parameter int MASTER_EXTRA = 6
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_pin_n,
  input  logic              prog_pin_n,
  input  logic              init_sense,
  input  logic [MODE_W-1:0] mode_pins,
  input  logic              master_mode,
  input  logic              cclk_tick,
  input  logic [LEN_W-1:0]  length_count,
  input  logic              eoc_frame,
  input  logic              keep_mem,
  output logic              init_pull_low,
  output logic              hdc,
  output logic              ldc,
  output logic              done,
  output logic              mem_clear,
  output logic              io_active,
  output logic              int_rst_rel,
  output logic              dout_en,
  output logic [MODE_W-1:0] mode_latched,
  output logic [1:0]        phase
);
  logic [2:0] raw_in, syn_in;
  phase_e     ph;
  logic       clr_busy, load_done, live;

  assign raw_in = {init_sense, prog_pin_n, rst_pin_n};

  cfg_sync #(.W(3)) u_sync (
    .clk(clk), .por_n(por_n), .din(raw_in), .dout(syn_in)
  );

  cfg_phase_fsm #(
    .MODE_W(MODE_W), .CLR_CYC(CLR_CYC), .SU_CYC(SU_CYC),
    .SLAVE_SETTLE(SLAVE_SETTLE), .MASTER_EXTRA(MASTER_EXTRA)
  ) u_fsm (
    .clk(clk), .por_n(por_n),
    .s_init(syn_in[2]), .s_rst_n(syn_in[0]), .s_prog_n(syn_in[1]),
    .master_mode(master_mode), .keep_mem(keep_mem), .mode_pins(mode_pins),
    .load_done(load_done), .phase(ph), .clr_busy(clr_busy), .mode_q(mode_latched)
  );

  cfg_len_cnt #(.LEN_W(LEN_W)) u_len (
    .clk(clk), .por_n(por_n), .in_load(ph == PH_LOAD), .tick(cclk_tick),
    .eoc(eoc_frame), .load_len(length_count), .load_done(load_done)
  );

  assign live          = (ph == PH_START) || (ph == PH_RUN);
  assign phase         = ph;
  assign mem_clear     = clr_busy;
  assign init_pull_low = clr_busy;
  assign hdc           = !live;
  assign ldc           = live;
  assign done          = live;
  assign io_active     = live;
  assign int_rst_rel   = live;
  assign dout_en       = (ph == PH_LOAD);

  // R5
  dout_excl_chk: assert property (@(posedge clk) disable iff (!por_n)
    done |-> (!mem_clear && !dout_en));
  // R8
  start_from_load_chk: assert property (@(posedge clk) disable iff (!por_n)
    $rose(done) |-> ($past(dout_en) && $past(load_done)));
endmodule

// File: tb/cfg_seq_top_tb.sv
`timescale 1ns/1ps
module cfg_seq_top_tb;
  localparam int MODE_W = 4, LEN_W = 16, CLR_CYC = 8, SU_CYC = 4;
  localparam int NEED_S = 2, NEED_M = 8;

  logic clk = 0;
  always #4 clk = ~clk;

  logic por_n = 0, rst_pin_n = 1, prog_pin_n = 1, ext_init_n = 1;
  logic [MODE_W-1:0] mode_pins = '0;
  logic master_mode = 0, cclk_tick = 0, eoc_frame = 0, keep_mem = 0;
  logic [LEN_W-1:0] length_count = 16'd12;
  logic init_pull_low, hdc, ldc, done, mem_clear, io_active, int_rst_rel, dout_en;
  logic [MODE_W-1:0] mode_latched;
  logic [1:0] phase;
  logic init_sense;
  assign init_sense = ext_init_n & ~init_pull_low;

  cfg_seq_top u_dut (
    .clk(clk), .por_n(por_n), .rst_pin_n(rst_pin_n), .prog_pin_n(prog_pin_n),
    .init_sense(init_sense), .mode_pins(mode_pins), .master_mode(master_mode),
    .cclk_tick(cclk_tick), .length_count(length_count), .eoc_frame(eoc_frame),
    .keep_mem(keep_mem), .init_pull_low(init_pull_low), .hdc(hdc), .ldc(ldc),
    .done(done), .mem_clear(mem_clear), .io_active(io_active),
    .int_rst_rel(int_rst_rel), .dout_en(dout_en), .mode_latched(mode_latched),
    .phase(phase)
  );

  int total = 0, bad = 0;
  task automatic check(input bit ok, input string req, input int got, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s got=%0d exp=%0d at %0t", req, got, exp, $time);
    end
  endtask

  // reference model: phase number, counters as plain integers, sync as queues
  int m_ph, m_clr, m_run, m_len, m_su;
  bit m_eoc, m_once;
  int m_mode;
  bit q_init[$], q_rst[$], q_prog[$];

  function automatic bit m_pull();
    return (m_ph == 0) && (m_clr > 0);
  endfunction

  always @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      m_ph = 0; m_clr = CLR_CYC; m_run = 0; m_len = 0; m_su = 0;
      m_eoc = 0; m_once = 0; m_mode = 0;
      q_init = '{0, 0}; q_rst = '{0, 0}; q_prog = '{0, 0};
    end else begin
      bit si, sr, sp, fin, pull;
      int need, nph;
      si = q_init[1]; sr = q_rst[1]; sp = q_prog[1];
      pull = m_pull();
      void'(q_init.pop_back()); q_init.push_front(ext_init_n & ~pull);
      void'(q_rst.pop_back());  q_rst.push_front(rst_pin_n);
      void'(q_prog.pop_back()); q_prog.push_front(prog_pin_n);
      fin = (m_ph == 1) && (m_len == int'(length_count)) && (m_eoc || eoc_frame);
      need = master_mode ? NEED_M : NEED_S;
      nph = m_ph;
      if (m_ph == 1) begin
        if (cclk_tick) m_len = (m_len + 1) % (1 << LEN_W);
        if (eoc_frame) m_eoc = 1;
      end else begin
        m_len = 0; m_eoc = 0;
      end
      case (m_ph)
        0: begin
          bit ok;
          ok = (m_clr == 0) && si && sr && sp;
          if (m_clr > 0) m_clr--;
          if (ok) begin
            m_run++;
            if (m_run == need) begin nph = 1; m_mode = mode_pins; m_run = 0; end
          end else m_run = 0;
        end
        1: if (!sr || !sp) begin nph = 0; m_clr = (keep_mem && m_once) ? 0 : CLR_CYC; end
           else if (fin) begin nph = 2; m_su = 0; m_once = 1; end
        2: if (!sp) begin nph = 0; m_clr = (keep_mem && m_once) ? 0 : CLR_CYC; end
           else begin m_su++; if (m_su == SU_CYC) nph = 3; end
        default: if (!sp) begin nph = 0; m_clr = (keep_mem && m_once) ? 0 : CLR_CYC; end
      endcase
      m_ph = nph;
    end
  end

  bit cmp_on = 0;
  always @(negedge clk) if (cmp_on) begin
    bit live;
    live = (m_ph >= 2);
    check(phase == 2'(m_ph), "R3/R6/R7 phase", phase, m_ph);
    check(mem_clear == m_pull(), "R1/R11 mem_clear", mem_clear, m_pull());
    check(init_pull_low == m_pull(), "R2 init_pull_low", init_pull_low, m_pull());
    check(hdc == !live && ldc == live, "R10 hdc/ldc", {hdc, ldc}, {!live, live});
    check(done == live && io_active == live && int_rst_rel == live, "R8 done/io/rel",
          {done, io_active, int_rst_rel}, {3{live}});
    check(dout_en == (m_ph == 1), "R5 dout_en", dout_en, m_ph == 1);
    check(mode_latched == MODE_W'(m_mode), "R3 mode_latched", mode_latched, m_mode);
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      bad++; total++;
      $display("FAIL watchdog got=%0d exp=%0d", cyc, 20000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic wait_phase(input int p, input string req);
    int k;
    k = 0;
    while (phase != 2'(p) && k < 200) begin step(1); k++; end
    check(phase == 2'(p), req, phase, p);
  endtask

  task automatic tick_run(input int n);
    for (int i = 0; i < n; i++) begin
      cclk_tick = 1; step(1); cclk_tick = 0; step($urandom_range(0, 2));
    end
  endtask

  initial begin
    step(3);
    por_n = 1; ext_init_n = 0; mode_pins = 4'hA; cmp_on = 1;
    step(1);
    check(mem_clear == 1 && phase == 0 && hdc == 1, "R1 reset state", mem_clear, 1);
    step(20);
    check(phase == 0, "R2 held by outside", phase, 0);
    ext_init_n = 1;
    step(2);
    check(phase == 0, "R12 sync delay", phase, 0);
    wait_phase(1, "R3 slave entry");
    check(mode_latched == 4'hA, "R3 mode", mode_latched, 4'hA);
    tick_run(3);
    eoc_frame = 1; step(1); eoc_frame = 0;
    tick_run(9);
    wait_phase(2, "R6 completion");
    check(done == 1, "R8 done", done, 1);
    wait_phase(3, "R8 operation");
    rst_pin_n = 0; step(10);
    check(phase == 3, "R9 reset ignored", phase, 3);
    rst_pin_n = 1;
    keep_mem = 1; master_mode = 1; mode_pins = 4'h5; length_count = 16'd5;
    prog_pin_n = 0; step(4); prog_pin_n = 1;
    wait_phase(0, "R9 prog reconfig");
    check(mem_clear == 0, "R11 clear skipped", mem_clear, 0);
    wait_phase(1, "R4 master entry");
    tick_run(2);
    rst_pin_n = 0;
    wait_phase(0, "R7 abort");
    step(20);
    check(phase == 0, "R7 held while reset low", phase, 0);
    rst_pin_n = 1;
    wait_phase(1, "R7 re-entry");
    tick_run(5);
    step(6);
    check(phase == 1, "R6 no end frame yet", phase, 1);
    eoc_frame = 1; step(1); eoc_frame = 0;
    wait_phase(2, "R6 end frame late");
    wait_phase(3, "R8 operation again");
    step(4);
    cmp_on = 0;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule